// File: doc/BRIEF.md
# Display and Host Shared Data Bus Arbiter

This block lets two users share one 8-bit data bus. A refresh engine walks through a fixed set of display latch slots. For each slot it puts a status byte on the data pins and pulses that slot's latch strobe. A host processor reaches a bank of on-chip registers through the same pins, choosing a register with a 5-bit address. The host data bus sits behind an external tri-state isolation buffer. The block controls both the enable and the direction of that buffer.

Display refresh owns the bus by default, with the block driving the pins. A host request is accepted only at the boundary between display cycles. The isolation buffer opens only while the display latches are idle, so a latch can never capture host traffic. One released clock separates every hand-over between display and host, in either direction. The status bytes enter as a flat input vector. The register bank is a plain array that the host reads and writes.

Top module: `bus_share_arb`

## Requirements
- R1: While reset is active, the data pins are released (`pad_oe`=0), the buffer is disabled, no strobe is active and `host_rdy` is low.
- R2: A display cycle takes three clocks with `pad_oe`=1 and the same byte on `pad_out` in all three. Only the middle clock raises a strobe, and no more than one strobe bit is high at any time.
- R3: Display cycles visit the slots in order 0, 1, ..., NSLOT-1 and then wrap to 0. Slot k drives bit k of `disp_stb`, and every slot is refreshed repeatedly.
- R4: A pending host request never breaks into a display cycle. It is granted after the current display cycle ends, so no more than one strobe occurs between the request and the opening of the buffer.
- R5: Between a display cycle and a host access, in either order, there is at least one clock in which `pad_oe`=0, `buf_en`=0 and no strobe is active.
- R6: A host read (`host_wr`=0) sets `buf_en`=1 and `buf_to_host`=1 and drives the addressed register onto `pad_out` with `pad_oe`=1. `host_rdy` goes high for one clock on the second access clock, and the data is valid in that clock.
- R7: A host write (`host_wr`=1) sets `buf_en`=1, `buf_to_host`=0 and `pad_oe`=0. The byte on `pad_in` is stored in the addressed register in the clock where `host_rdy` is high, and every other register keeps its value.
- R8: `buf_en` is never high in a clock where a display strobe is active or where the pins carry display data.
- R9: The byte shown for a slot is the value of that slot's field in `disp_src` (bits k*8+7..k*8) at the clock edge that starts the cycle. Later changes of `disp_src` do not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_src | input | NSLOT*DW | Status byte for each display slot, slot k in bits k*DW+DW-1..k*DW |
| disp_stb | output | NSLOT | One-clock latch strobe for each display slot |
| host_req | input | 1 | Host access request, held until `host_rdy` |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | AW | Register address |
| host_rdy | output | 1 | Read data valid or write data taken |
| buf_en | output | 1 | Enable for the external isolation buffer |
| buf_to_host | output | 1 | Buffer direction, 1 = chip to host |
| pad_out | output | DW | Data driven onto the shared pins |
| pad_oe | output | 1 | Output enable for the shared pins |
| pad_in | input | DW | Data received from the shared pins |

## Verification
The hardest case to reach is a host request that lands in each phase of a display cycle in turn: setup, strobe, hold and the released gap. The arbiter must still delay the grant to the cycle boundary. The refresh engine runs on its own, and the stimulus places each request after a random gap of 0 to 7 clocks, with some back-to-back requests. Over many accesses this sweeps the request across every phase, and the bench counts the strobes seen before each grant. `disp_src` also changes on every clock. This shows that each latched byte comes from the value at the start of its cycle and not from a later one.

// File: rtl/bus_share_arb.sv
module bus_share_arb #(
  parameter int DW    = 8,
  parameter int AW    = 5,
  parameter int NSLOT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT*DW-1:0] disp_src,
  output logic [NSLOT-1:0]   disp_stb,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [AW-1:0]      host_addr,
  output logic               host_rdy,
  output logic               buf_en,
  output logic               buf_to_host,
  output logic [DW-1:0]      pad_out,
  output logic               pad_oe,
  input  logic [DW-1:0]      pad_in
);

  localparam int NREG = 1 << AW;
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_DSET, S_DSTB, S_DHLD, S_HOPN, S_HDON
  } st_t;

  st_t             st;
  logic [SW-1:0]   slot;
  logic            go_host;
  logic [DW-1:0]   disp_q;
  logic            h_wr;
  logic [AW-1:0]   h_addr;
  logic [DW-1:0]   regs [NREG];

  wire [SW-1:0] slot_nx  = (slot == SW'(NSLOT - 1)) ? '0 : slot + 1'b1;
  wire          disp_drv = (st == S_DSET) || (st == S_DSTB) || (st == S_DHLD);
  wire          host_on  = (st == S_HOPN) || (st == S_HDON);
  wire          host_rd  = host_on && !h_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      slot    <= '0;
      go_host <= 1'b0;
      disp_q  <= '0;
      h_wr    <= 1'b0;
      h_addr  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_host) begin
            st      <= S_HOPN;
            go_host <= 1'b0;
            h_wr    <= host_wr;
            h_addr  <= host_addr;
          end else begin
            st     <= S_DSET;
            disp_q <= disp_src[int'(slot)*DW +: DW];
          end
        end
        S_DSET: st <= S_DSTB;
        S_DSTB: st <= S_DHLD;
        S_DHLD: begin
          slot <= slot_nx;
          if (host_req) begin
            go_host <= 1'b1;
            st      <= S_IDLE;
          end else begin
            st     <= S_DSET;
            disp_q <= disp_src[int'(slot_nx)*DW +: DW];
          end
        end
        S_HOPN: st <= S_HDON;
        S_HDON: begin
          if (h_wr) regs[h_addr] <= pad_in;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign disp_stb    = (st == S_DSTB) ? (NSLOT'(1) << slot) : '0;
  assign host_rdy    = (st == S_HDON);
  assign buf_en      = host_on;
  assign buf_to_host = host_rd;
  assign pad_oe      = disp_drv || host_rd;
  assign pad_out     = disp_drv ? disp_q : (host_rd ? regs[h_addr] : '0);

  // R8
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (disp_stb == '0));

  // R2
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_stb));

  // R2
  stb_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_stb) |-> (pad_oe && $stable(pad_out) && $past(pad_oe) && !$past(buf_en)));

  // R2
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_stb) |=> (pad_oe && !buf_en && $stable(pad_out) && disp_stb == '0));

  // R6
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && buf_to_host) |-> pad_oe);

  // R7
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !buf_to_host) |-> !pad_oe);

  // R5
  turn_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_en) |-> !$past(pad_oe));

  // R5
  turn_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_en) |-> (!pad_oe && disp_stb == '0));

  // R6
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdy |=> !host_rdy);

  // R4
  req_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_stb) |=> !buf_en);

endmodule

// File: tb/sim_bus_share_arb.sv
`timescale 1ns/1ps
module sim_bus_share_arb;
  localparam int DW = 8, AW = 5, NSLOT = 6, NREG = 32;

  logic clk = 0, rst_n = 0;
  logic [NSLOT*DW-1:0] disp_src = '0;
  logic [NSLOT-1:0] disp_stb;
  logic host_req = 0, host_wr = 0, host_rdy;
  logic [AW-1:0] host_addr = '0;
  logic buf_en, buf_to_host, pad_oe;
  logic [DW-1:0] pad_out, pad_in, wdat = '0;

  int n_cmp = 0, n_bad = 0, exp_slot = 0, wait_stb = 0;
  int seen [NSLOT];
  logic [DW-1:0] mirror [NREG];
  logic [NSLOT*DW-1:0] src_h1 = '0, src_h2 = '0;
  logic prev_buf = 0, prev_oe = 0, prev_stb = 0, after_stb = 0, src_run = 0;
  logic [DW-1:0] prev_out = '0, stb_out = '0;

  always #4 clk = ~clk;

  assign pad_in = (buf_en && !buf_to_host) ? wdat : 8'hA5;

  bus_share_arb #(.DW(DW), .AW(AW), .NSLOT(NSLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .disp_src(disp_src), .disp_stb(disp_stb),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_rdy(host_rdy), .buf_en(buf_en), .buf_to_host(buf_to_host),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] slot_byte(input logic [NSLOT*DW-1:0] v, input int k);
    return v[k*DW +: DW];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (|disp_stb) begin
        chk($onehot(disp_stb), "R2 strobe one-hot", disp_stb, 0);
        chk(disp_stb == (NSLOT'(1) << exp_slot), "R3 slot order", disp_stb, NSLOT'(1) << exp_slot);
        chk(pad_oe && pad_out == slot_byte(src_h2, exp_slot), "R9 latched byte", pad_out, slot_byte(src_h2, exp_slot));
        chk(!buf_en, "R8 buffer off at strobe", buf_en, 0);
        chk(prev_oe && pad_out == prev_out && !prev_stb, "R2 setup clock", prev_out, pad_out);
        seen[exp_slot]++;
        exp_slot = (exp_slot == NSLOT - 1) ? 0 : exp_slot + 1;
        after_stb = 1;
        stb_out = pad_out;
      end else if (after_stb) begin
        chk(pad_oe && pad_out == stb_out && !buf_en, "R2 hold clock", pad_out, stb_out);
        after_stb = 0;
      end
      if (buf_en && !prev_buf) begin
        chk(!prev_oe && !prev_stb, "R5 idle before host", prev_oe, 0);
        chk(wait_stb <= 1, "R4 grant at boundary", wait_stb, 1);
        wait_stb = 0;
      end else if (host_req && !buf_en && |disp_stb) wait_stb++;
      else if (!host_req) wait_stb = 0;
      if (!buf_en && prev_buf)
        chk(!pad_oe && disp_stb == '0, "R5 idle after host", pad_oe, 0);
    end
    src_h2 = src_h1;
    src_h1 = disp_src;
    prev_buf = buf_en;
    prev_oe = pad_oe;
    prev_out = pad_out;
    prev_stb = |disp_stb;
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      if (src_run) disp_src = {$urandom, $urandom};
    end
  end

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    host_req = 1; host_wr = 1; host_addr = a; wdat = d;
    do @(negedge clk); while (!host_rdy);
    chk(buf_en && !buf_to_host && !pad_oe, "R7 write direction", {buf_en, buf_to_host, pad_oe}, 3'b100);
    mirror[a] = d;
    @(posedge clk); #2;
    host_req = 0;
  endtask

  task automatic host_read(input logic [AW-1:0] a);
    @(posedge clk); #2;
    host_req = 1; host_wr = 0; host_addr = a;
    do @(negedge clk); while (!host_rdy);
    chk(buf_en && buf_to_host && pad_oe, "R6 read direction", {buf_en, buf_to_host, pad_oe}, 3'b111);
    chk(pad_out == mirror[a], "R6/R7 read data", pad_out, mirror[a]);
    @(posedge clk); #2;
    host_req = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < NREG; i++) mirror[i] = '0;
    for (int i = 0; i < NSLOT; i++) seen[i] = 0;
    disp_src = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    // R1
    chk(!pad_oe && !buf_en && disp_stb == '0 && !host_rdy, "R1 reset state",
        {pad_oe, buf_en, |disp_stb, host_rdy}, 0);
    @(posedge clk); #2;
    rst_n = 1;
    src_run = 1;
    gap(20);
    host_write(5'd0, 8'h3C);
    host_write(5'd31, 8'hC3);
    host_read(5'd0);
    host_read(5'd31);
    host_read(5'd7);
    for (int n = 0; n < 120; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, NREG - 1));
      if ($urandom_range(0, 1) == 1) host_write(a, DW'($urandom));
      else host_read(a);
      if (n % 10 != 0) gap($urandom_range(0, 7));
    end
    for (int i = 0; i < NREG; i++) host_read(AW'(i));
    gap(40);
    for (int i = 0; i < NSLOT; i++)
      chk(seen[i] > 1, "R3 every slot refreshed", seen[i], 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule